// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sequences external memory accesses for a small 8-bit controller whose bus pins are scarce. One 8-bit port carries the low address byte first and then the data byte. An address strobe frames the low byte so that an outside transparent latch can hold it. A second 8-bit port carries the high address byte. The core issues three kinds of request: program fetch, data read and data write. Each accepted request runs for exactly one 12-clock machine cycle. At the end of that cycle the block pulses `done`, and for reads it presents the captured byte on `rdata`.

Addresses come from one of three sources. A plain request supplies a 16-bit address. An indexed fetch adds the 8-bit accumulator to a 16-bit base, which is either the data pointer or the program counter. A paged (narrow) data access uses only the low byte and leaves the high port undriven, so that port stays free for general I/O. A build option provides a merged read strobe that goes low whenever the fetch strobe or the data-read strobe is low. This lets program space and data space share one external memory.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, the block is idle. In that state `addr_stb`=0, `fetch_stb_n`, `dread_stb_n`, `dwrite_stb_n` and `anyrd_stb_n` are 1, `lo_oe`=0, `hi_oe`=0, `done`=0, `busy`=0 and `rdata`=0.
- R2: Phases 0..11 are the twelve clocks of an access, with phase 0 being the cycle after acceptance. `addr_stb` is high in phases 0..2 only. `lo_oe` is high in phases 0..3, with `lo_out` equal to the address bits 7:0.
- R3: A fetch (`req_kind`=2'b00) drives `fetch_stb_n` low in phases 5..9 and nowhere else, and does not drive `lo_oe` after phase 3. `rdata` takes the value of `lo_in` sampled at the clock edge that ends phase 9.
- R4: A data read (`req_kind`=2'b01) drives `dread_stb_n` low in phases 4..10, so its window is longer than a fetch's, and does not drive `lo_oe` after phase 3. `rdata` takes `lo_in` sampled at the edge that ends phase 10.
- R5: A data write (`req_kind`=2'b10) drives `dwrite_stb_n` low in phases 4..10. `lo_oe` stays high through phase 11 with `lo_out`=`req_wdata`, so the data is held for one clock after the strobe rises.
- R6: An access that is not narrow drives `hi_oe` high in phases 0..11, with `hi_out` equal to the address bits 15:8, held constant.
- R7: A narrow data access (`req_narrow`=1 with a read or write kind) keeps `hi_oe` low throughout and puts `req_addr[7:0]` on `lo_out`. For fetches, `req_narrow` has no effect.
- R8: A fetch with `req_index`=1 uses the address (base + `req_acc`) mod 65536. The base is `req_pc` when `req_index_pc`=1 and `req_dptr` otherwise. For data kinds, `req_index` is ignored and `req_addr` is used.
- R9: With `MERGE_RD`=1, `anyrd_stb_n` is low exactly when `fetch_stb_n` or `dread_stb_n` is low.
- R10: `busy` is high in phases 0..11. `done` is a single-cycle pulse in phase 11.
- R11: A request is ignored while `busy` is high, including in phase 11. A request of kind 2'b11 is always ignored. In both cases an idle cycle with `busy`=0 follows every access.
- R12: At most one of the three access strobes is low at a time, and `addr_stb` is never high while one of them is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write, 11 none |
| req_narrow | input | 1 | Paged 8-bit data access |
| req_index | input | 1 | Fetch address is base plus accumulator |
| req_index_pc | input | 1 | Index base: 1 program counter, 0 data pointer |
| req_addr | input | 16 | Direct or pointer address |
| req_dptr | input | 16 | Data pointer base |
| req_pc | input | 16 | Program counter base |
| req_acc | input | 8 | Accumulator offset |
| req_wdata | input | 8 | Write byte |
| lo_in | input | 8 | Shared port input |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final-phase pulse |
| rdata | output | 8 | Last byte read |
| addr_stb | output | 1 | Address latch strobe, active high |
| fetch_stb_n | output | 1 | Program read strobe, active low |
| dread_stb_n | output | 1 | Data read strobe, active low |
| dwrite_stb_n | output | 1 | Data write strobe, active low |
| anyrd_stb_n | output | 1 | Merged read strobe, active low |
| lo_out | output | 8 | Shared port output (address low, then data) |
| lo_oe | output | 1 | Shared port drive enable |
| hi_out | output | 8 | High address port output |
| hi_oe | output | 1 | High address port drive enable |

## Verification
Two events can land on the same clock. The `done` pulse of phase 11 can coincide with a new request. The same phase can also see the rising edge of the write strobe while the write byte is still driven. The bench keeps `req_valid` asserted with changing fields during the whole access and into its final phase. The per-clock model then confirms that no access starts until the idle cycle, and that the address and data seen on the ports belong to the originally latched request. On writes, every clock compares the shared-port enable and value in phase 11, while the write strobe has already returned high.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    parameter int ADDR_W = 16;
    parameter int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'b00,
        ACC_DREAD  = 2'b01,
        ACC_DWRITE = 2'b10,
        ACC_NONE   = 2'b11
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e         kind;
        logic              narrow;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } acc_desc_t;

    function automatic logic in_win(input int p, input int lo, input int hi);
        return (p >= lo) && (p <= hi);
    endfunction

endpackage

// File: rtl/xbus_addr.sv
module xbus_addr
    import xbus_pkg::*;
(
    input  acc_kind_e         kind,
    input  logic              narrow,
    input  logic              index_en,
    input  logic              index_pc,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] wdata,
    output acc_desc_t         desc
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] indexed;
    logic              is_fetch;
    logic              narrow_eff;

    assign is_fetch   = (kind == ACC_FETCH);
    assign narrow_eff = narrow && !is_fetch;
    assign base       = index_pc ? pc : dptr;
    assign indexed    = base + {{HI_W{1'b0}}, acc};

    always_comb begin
        desc.kind   = kind;
        desc.narrow = narrow_eff;
        desc.wdata  = wdata;
        if (is_fetch && index_en)
            desc.addr = indexed;
        else if (narrow_eff)
            desc.addr = {{HI_W{1'b0}}, addr_in[BYTE_W-1:0]};
        else
            desc.addr = addr_in;
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int MC_LAST = 11,
    parameter int PH_W    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  acc_desc_t       desc_in,
    output logic            busy,
    output logic [PH_W-1:0] ph,
    output acc_desc_t       desc_q
);
    logic accept;
    logic last;

    assign accept = req_valid && !busy && (desc_in.kind != ACC_NONE);
    assign last   = busy && (ph == PH_W'(MC_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ph     <= '0;
            desc_q <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            ph     <= '0;
            desc_q <= desc_in;
        end else if (last) begin
            busy <= 1'b0;
            ph   <= '0;
        end else if (busy) begin
            ph <= ph + 1'b1;
        end
    end
endmodule

// File: rtl/xbus_phy.sv
module xbus_phy
    import xbus_pkg::*;
#(
    parameter int MC_LAST    = 11,
    parameter int ALE_LAST   = 2,
    parameter int ADDR_LAST  = 3,
    parameter int STRB_FIRST = 4,
    parameter int PGM_FIRST  = 5,
    parameter int PGM_LAST   = 9,
    parameter int DAT_LAST   = 10,
    parameter int PH_W       = 4
) (
    input  logic              busy,
    input  logic [PH_W-1:0]   ph,
    input  acc_desc_t         desc,
    output logic              addr_stb,
    output logic              fetch_stb_n,
    output logic              dread_stb_n,
    output logic              dwrite_stb_n,
    output logic [BYTE_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [BYTE_W-1:0] hi_out,
    output logic              hi_oe,
    output logic              sample,
    output logic              done
);
    int   p;
    logic is_f, is_r, is_w, addr_phase;

    assign p          = int'(ph);
    assign is_f       = busy && (desc.kind == ACC_FETCH);
    assign is_r       = busy && (desc.kind == ACC_DREAD);
    assign is_w       = busy && (desc.kind == ACC_DWRITE);
    assign addr_phase = busy && (p <= ADDR_LAST);

    assign addr_stb     = busy && (p <= ALE_LAST);
    assign fetch_stb_n  = !(is_f && in_win(p, PGM_FIRST, PGM_LAST));
    assign dread_stb_n  = !(is_r && in_win(p, STRB_FIRST, DAT_LAST));
    assign dwrite_stb_n = !(is_w && in_win(p, STRB_FIRST, DAT_LAST));

    assign lo_oe  = addr_phase || (is_w && in_win(p, ADDR_LAST + 1, MC_LAST));
    assign lo_out = addr_phase ? desc.addr[BYTE_W-1:0] :
                    (is_w ? desc.wdata : '0);

    assign hi_oe  = busy && !desc.narrow;
    assign hi_out = hi_oe ? desc.addr[ADDR_W-1:BYTE_W] : '0;

    assign sample = (is_f && (p == PGM_LAST)) || (is_r && (p == DAT_LAST));
    assign done   = busy && (p == MC_LAST);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int MERGE_RD   = 1,
    parameter int MC_LAST    = 11,
    parameter int ALE_LAST   = 2,
    parameter int ADDR_LAST  = 3,
    parameter int STRB_FIRST = 4,
    parameter int PGM_FIRST  = 5,
    parameter int PGM_LAST   = 9,
    parameter int DAT_LAST   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic        req_narrow,
    input  logic        req_index,
    input  logic        req_index_pc,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_dptr,
    input  logic [15:0] req_pc,
    input  logic [7:0]  req_acc,
    input  logic [7:0]  req_wdata,
    input  logic [7:0]  lo_in,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rdata,
    output logic        addr_stb,
    output logic        fetch_stb_n,
    output logic        dread_stb_n,
    output logic        dwrite_stb_n,
    output logic        anyrd_stb_n,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    output logic [7:0]  hi_out,
    output logic        hi_oe
);
    localparam int PH_W = $clog2(MC_LAST + 1);

    acc_desc_t       desc_new;
    acc_desc_t       desc_q;
    logic [PH_W-1:0] ph;
    logic            sample;

    xbus_addr u_addr (
        .kind     (acc_kind_e'(req_kind)),
        .narrow   (req_narrow),
        .index_en (req_index),
        .index_pc (req_index_pc),
        .addr_in  (req_addr),
        .dptr     (req_dptr),
        .pc       (req_pc),
        .acc      (req_acc),
        .wdata    (req_wdata),
        .desc     (desc_new)
    );

    xbus_seq #(.MC_LAST(MC_LAST), .PH_W(PH_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .desc_in   (desc_new),
        .busy      (busy),
        .ph        (ph),
        .desc_q    (desc_q)
    );

    xbus_phy #(
        .MC_LAST(MC_LAST), .ALE_LAST(ALE_LAST), .ADDR_LAST(ADDR_LAST),
        .STRB_FIRST(STRB_FIRST), .PGM_FIRST(PGM_FIRST), .PGM_LAST(PGM_LAST),
        .DAT_LAST(DAT_LAST), .PH_W(PH_W)
    ) u_phy (
        .busy         (busy),
        .ph           (ph),
        .desc         (desc_q),
        .addr_stb     (addr_stb),
        .fetch_stb_n  (fetch_stb_n),
        .dread_stb_n  (dread_stb_n),
        .dwrite_stb_n (dwrite_stb_n),
        .lo_out       (lo_out),
        .lo_oe        (lo_oe),
        .hi_out       (hi_out),
        .hi_oe        (hi_oe),
        .sample       (sample),
        .done         (done)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (sample)
            rdata <= lo_in;
    end

    generate
        if (MERGE_RD != 0) begin : g_merge
            assign anyrd_stb_n = fetch_stb_n & dread_stb_n;
        end else begin : g_split
            assign anyrd_stb_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
    input logic       clk,
    input logic       rst,
    input logic       addr_stb,
    input logic       fetch_stb_n,
    input logic       dread_stb_n,
    input logic       dwrite_stb_n,
    input logic       lo_oe,
    input logic       hi_oe,
    input logic [7:0] hi_out,
    input logic       done,
    input logic       busy
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!addr_stb && fetch_stb_n && dread_stb_n && dwrite_stb_n
                 && !lo_oe && !hi_oe && !done && !busy));

    assert_addr_open_R2: assert property (@(posedge clk) disable iff (rst)
        addr_stb |-> lo_oe);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_stb) |-> lo_oe);

    assert_fetch_nofight_R3: assert property (@(posedge clk) disable iff (rst)
        !fetch_stb_n |-> !lo_oe);

    assert_read_nofight_R4: assert property (@(posedge clk) disable iff (rst)
        !dread_stb_n |-> !lo_oe);

    assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dwrite_stb_n) |-> lo_oe);

    assert_hi_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (hi_oe && $past(hi_oe)) |-> $stable(hi_out));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_no_accept_in_final_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!fetch_stb_n, !dread_stb_n, !dwrite_stb_n}));

    assert_latch_closed_R12: assert property (@(posedge clk) disable iff (rst)
        (!fetch_stb_n || !dread_stb_n || !dwrite_stb_n) |-> !addr_stb);
endmodule

bind xbus_ctrl xbus_chk i_chk (.*);

// File: tb/test_xbus_ctrl.sv
`timescale 1ns/1ps
module test_xbus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b11;
    logic        req_narrow = 1'b0, req_index = 1'b0, req_index_pc = 1'b0;
    logic [15:0] req_addr = '0, req_dptr = '0, req_pc = '0;
    logic [7:0]  req_acc = '0, req_wdata = '0, lo_in = '0;
    logic        busy, done, addr_stb, fetch_stb_n, dread_stb_n, dwrite_stb_n;
    logic        anyrd_stb_n, lo_oe, hi_oe;
    logic [7:0]  rdata, lo_out, hi_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    xbus_ctrl i_xbus_ctrl (.*);

    // behavioural reference: phase -1 means idle
    int          m_ph = -1;
    int          m_kind = 0;
    bit          m_narrow = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rdata = '0;

    function automatic logic [15:0] ref_addr();
        if (req_kind == 2'b00 && req_index)
            return (req_index_pc ? req_pc : req_dptr) + 16'(req_acc);
        if (req_kind != 2'b00 && req_narrow)
            return {8'h00, req_addr[7:0]};
        return req_addr;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph    <= -1;
            m_rdata <= '0;
        end else begin
            if ((m_kind == 0 && m_ph == 9) || (m_kind == 1 && m_ph == 10))
                m_rdata <= lo_in;
            if (m_ph < 0) begin
                if (req_valid && req_kind != 2'b11) begin
                    m_ph     <= 0;
                    m_kind   <= int'(req_kind);
                    m_narrow <= req_narrow && (req_kind != 2'b00);
                    m_addr   <= ref_addr();
                    m_wdata  <= req_wdata;
                end
            end else if (m_ph == 11) begin
                m_ph <= -1;
            end else begin
                m_ph <= m_ph + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            automatic bit act = (m_ph >= 0);
            automatic int p = m_ph;
            automatic bit e_f = !(act && m_kind == 0 && p >= 5 && p <= 9);
            automatic bit e_r = !(act && m_kind == 1 && p >= 4 && p <= 10);
            automatic bit e_w = !(act && m_kind == 2 && p >= 4 && p <= 10);
            automatic bit e_lo = act && (p <= 3 || m_kind == 2);
            automatic bit e_hi = act && !m_narrow;
            chk("R2 addr_stb", 16'(addr_stb), 16'(act && p <= 2));
            chk("R3 fetch_stb_n", 16'(fetch_stb_n), 16'(e_f));
            chk("R4 dread_stb_n", 16'(dread_stb_n), 16'(e_r));
            chk("R5 dwrite_stb_n", 16'(dwrite_stb_n), 16'(e_w));
            chk("R2/R5 lo_oe", 16'(lo_oe), 16'(e_lo));
            if (e_lo)
                chk("R2/R5 lo_out", 16'(lo_out), 16'(p <= 3 ? m_addr[7:0] : m_wdata));
            chk("R6/R7 hi_oe", 16'(hi_oe), 16'(e_hi));
            if (e_hi)
                chk("R6 hi_out", 16'(hi_out), 16'(m_addr[15:8]));
            chk("R9 anyrd_stb_n", 16'(anyrd_stb_n), 16'(e_f & e_r));
            chk("R10 busy", 16'(busy), 16'(act));
            chk("R10 done", 16'(done), 16'(act && p == 11));
            chk("R3/R4 rdata", 16'(rdata), 16'(m_rdata));
            chk("R12 strobes", 16'((!fetch_stb_n + !dread_stb_n + !dwrite_stb_n) <= 1
                                   && !(addr_stb && !(fetch_stb_n && dread_stb_n && dwrite_stb_n))), 16'(1));
        end
    end

    // shared-port input changes every clock so sample timing is visible
    initial begin
        forever begin
            @(negedge clk);
            #1 lo_in = 8'($urandom);
        end
    end

    // issue one request, hold req_valid with other fields during the access,
    // return the {hi,lo} address seen in phase 0
    task automatic issue(input logic [1:0] k, input logic [15:0] a, input bit nar,
                         input bit idx, input bit idxpc, input logic [15:0] dp,
                         input logic [15:0] pcv, input logic [7:0] ac,
                         input logic [7:0] wd, output logic [15:0] seen);
        @(negedge clk);
        #1;
        req_valid = 1'b1; req_kind = k; req_addr = a; req_narrow = nar;
        req_index = idx; req_index_pc = idxpc; req_dptr = dp; req_pc = pcv;
        req_acc = ac; req_wdata = wd;
        @(negedge clk);
        seen = {hi_oe ? hi_out : 8'h00, lo_out};
        #1;
        req_kind = 2'($urandom_range(0, 2));
        req_addr = 16'($urandom); req_wdata = 8'($urandom); req_narrow = 1'b0;
        repeat (11) @(negedge clk);
        #1 req_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] seen;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {addr_stb, fetch_stb_n, dread_stb_n, dwrite_stb_n, anyrd_stb_n},
            16'b0_1111);
        chk("R1 reset drives", {lo_oe, hi_oe, done, busy}, 16'h0);
        chk("R1 reset rdata", 16'(rdata), 16'h0);
        #1 rst = 1'b0;
        @(negedge clk);
        cmp_on = 1;

        issue(2'b00, 16'h1234, 1'b0, 1'b0, 1'b0, 0, 0, 0, 0, seen);
        chk("R3 plain fetch address", seen, 16'h1234);
        issue(2'b00, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h2F00, 16'h9999, 8'h45, 0, seen);
        chk("R8 dptr index, R7 narrow ignored on fetch", seen, 16'h2F45);
        issue(2'b00, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h1111, 16'hFFF0, 8'h20, 0, seen);
        chk("R8 pc index wrap", seen, 16'h0010);
        issue(2'b01, 16'hABCD, 1'b0, 1'b1, 1'b1, 16'h1111, 16'h2222, 8'h05, 0, seen);
        chk("R8 index ignored on data read", seen, 16'hABCD);
        issue(2'b01, 16'h77C3, 1'b1, 1'b0, 1'b0, 0, 0, 0, 0, seen);
        chk("R7 narrow read address", seen, 16'h00C3);
        issue(2'b10, 16'h5A5A, 1'b0, 1'b0, 1'b0, 0, 0, 0, 8'h3C, seen);
        chk("R5 write address", seen, 16'h5A5A);
        issue(2'b10, 16'hFF81, 1'b1, 1'b0, 1'b0, 0, 0, 0, 8'hE7, seen);
        chk("R7 narrow write address", seen, 16'h0081);

        // kind 11 is never accepted
        @(negedge clk);
        #1 req_valid = 1'b1; req_kind = 2'b11;
        repeat (5) @(negedge clk);
        chk("R11 kind 11 ignored", 16'(busy), 16'h0);
        #1 req_valid = 1'b0;

        for (int i = 0; i < 40; i++) begin
            issue(2'($urandom_range(0, 2)), 16'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 16'($urandom), 16'($urandom), 8'($urandom),
                  8'($urandom), seen);
        end
        repeat (4) @(negedge clk);
        chk("R11 idle after last request", 16'(busy), 16'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule